// File: doc/BRIEF.md
# Instruction-Fetch Performance Counter

This block is the instruction-memory slave of a soft processor. It answers every code fetch from a small on-chip read-only store with a one-cycle read latency. Each accepted fetch counts as one executed instruction. A second counter advances on every clock, so software can take cycles minus instructions as the number of cycles lost to stalls. This gives an exact instructions-per-cycle figure for a benchmark. The count is exact only if no instruction cache sits between the processor and this port, so that every fetch reaches it.

A small register port holds the control bits, a programmable instruction-count threshold and both counts. When the instruction count reaches the threshold, a sticky trigger output goes high. It can start or stop an external measurement, for example after one million instructions. The counters are 40 bits wide by default, so runs of well over a billion instructions do not wrap. Each count is read as a low word and a high word, and reading the low word freezes a copy of the high word so that the two halves belong together.

Top module: `ifetch_perf_counter`

## Requirements
- R1: An accepted fetch (fetch_req high and fetch_wait low at a rising edge) returns the word ((addr × 0x9E3779B1) mod 2^32) XOR ROM_SEED on fetch_rdata. fetch_rvalid is high for exactly the one clock that follows the accepting edge.
- R2: With WAIT_STATES = N, a new request sees fetch_wait high for its first N cycles, and the request is accepted on the following cycle. A request held through those wait cycles counts as one instruction.
- R3: The instruction counter increments by one per accepted fetch while control bit 0 (enable) is 1. Fetches made while enable is 0 return data but are not counted.
- R4: The cycle counter increments by one on every rising edge at which enable is 1. It never falls below the instruction count.
- R5: Register port word addresses are 0 control, 1 threshold bits 31:0, 2 threshold upper bits, 3 instruction count low, 4 instruction count high, 5 cycle count low, 6 cycle count high. reg_rdata presents the selected word one clock after reg_rd.
- R6: Reading address 3 or 5 captures the upper count bits (bit 32 and above) of that counter. A later read of address 4 or 6 returns that captured value, zero-extended.
- R7: count_trigger goes high one clock after the instruction count is greater than or equal to a nonzero threshold. It stays high until cleared. While it is high, control read bit 2 reads 1.
- R8: Writing the control word with bit 1 set zeroes both counters and the trigger at that edge. Bit 0 of the same write sets the new enable.
- R9: Synchronous active-high rst zeroes both counters, the threshold, the enable bit and the trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req | input | 1 | Code fetch request, held until accepted |
| fetch_addr | input | AW | Word address of the fetch |
| fetch_wait | output | 1 | Request not accepted this cycle |
| fetch_rdata | output | 32 | Fetched instruction word |
| fetch_rvalid | output | 1 | fetch_rdata valid |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one clock after reg_rd |
| count_trigger | output | 1 | Sticky threshold-reached flag |

## Verification
Fetches are driven at the lowest and highest address and at scattered addresses in between. They run both with counting disabled and enabled, and the returned words are compared against the address-derived pattern. This separates data errors from counting errors. Back-to-back fetches through wait states check that a held request counts once, and a cycle count taken over an exact window shows the lost cycles. A threshold test steps the count up to just below the threshold and then onto it, checks that the trigger stays sticky, and then uses a threshold with upper bits set. Together these show whether the compare is off by one, the upper word is ignored, or the clear path fails.

// File: rtl/ifpc_pkg.sv
package ifpc_pkg;
   localparam int REG_AW = 3;
   typedef enum logic [REG_AW-1:0] {
      RA_CTRL   = 3'd0,
      RA_THR_LO = 3'd1,
      RA_THR_HI = 3'd2,
      RA_INS_LO = 3'd3,
      RA_INS_HI = 3'd4,
      RA_CYC_LO = 3'd5,
      RA_CYC_HI = 3'd6
   } ifpc_reg_e;
   localparam int CTRL_EN_BIT  = 0;
   localparam int CTRL_CLR_BIT = 1;
   localparam int CTRL_TRG_BIT = 2;
endpackage

// File: rtl/ifpc_counter.sv
module ifpc_counter #(
   parameter int W = 40
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] count
);
   always_ff @(posedge clk) begin
      if (rst || clr) count <= '0;
      else if (inc)   count <= count + 1'b1;
   end
endmodule

// File: rtl/ifpc_fetch_port.sv
module ifpc_fetch_port #(
   parameter int          AW          = 10,
   parameter int          WAIT_STATES = 1,
   parameter logic [31:0] ROM_SEED    = 32'h5A5A0F0F
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          req,
   input  logic [AW-1:0] addr,
   output logic          wait_o,
   output logic [31:0]   rdata,
   output logic          rvalid,
   output logic          accept
);
   localparam int WW = (WAIT_STATES > 0) ? $clog2(WAIT_STATES + 1) : 1;

   function automatic logic [31:0] rom_word(input logic [AW-1:0] a);
      return (32'(a) * 32'h9E3779B1) ^ ROM_SEED;
   endfunction

   if (WAIT_STATES < 0) begin : g_bad_wait
      $error("WAIT_STATES must not be negative");
   end

   generate
      if (WAIT_STATES == 0) begin : g_nowait
         assign wait_o = 1'b0;
      end else begin : g_wait
         logic [WW-1:0] wcnt;
         assign wait_o = req && (wcnt != WW'(WAIT_STATES));
         always_ff @(posedge clk) begin
            if (rst)                wcnt <= '0;
            else if (req && wait_o) wcnt <= wcnt + 1'b1;
            else                    wcnt <= '0;
         end
      end
   endgenerate

   assign accept = req && !wait_o;

   always_ff @(posedge clk) begin
      if (rst) rvalid <= 1'b0;
      else     rvalid <= accept;
      if (accept) rdata <= rom_word(addr);
   end

   // R1
   rvalid_after_req_chk: assert property (@(posedge clk) disable iff (rst)
      rvalid |-> $past(req));
endmodule

// File: rtl/ifpc_regs.sv
module ifpc_regs
   import ifpc_pkg::*;
#(
   parameter int CNT_W = 40
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr,
   input  logic              rd,
   input  logic [REG_AW-1:0] addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   input  logic [CNT_W-1:0]  instr_cnt,
   input  logic [CNT_W-1:0]  cyc_cnt,
   output logic              enable,
   output logic              clr,
   output logic              trigger
);
   localparam int HI_W = CNT_W - 32;

   logic [CNT_W-1:0] thresh;
   logic [HI_W-1:0]  ins_shadow;
   logic [HI_W-1:0]  cyc_shadow;
   logic             ctrl_wr;

   assign ctrl_wr = wr && (ifpc_reg_e'(addr) == RA_CTRL);
   assign clr     = ctrl_wr && wdata[CTRL_CLR_BIT];

   always_ff @(posedge clk) begin
      if (rst) begin
         enable <= 1'b0;
         thresh <= '0;
      end else if (wr) begin
         case (ifpc_reg_e'(addr))
            RA_CTRL:   enable <= wdata[CTRL_EN_BIT];
            RA_THR_LO: thresh[31:0] <= wdata;
            RA_THR_HI: thresh[CNT_W-1:32] <= wdata[HI_W-1:0];
            default:   ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst || clr)                                 trigger <= 1'b0;
      else if ((thresh != '0) && (instr_cnt >= thresh)) trigger <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rdata      <= '0;
         ins_shadow <= '0;
         cyc_shadow <= '0;
      end else if (rd) begin
         case (ifpc_reg_e'(addr))
            RA_CTRL:   rdata <= 32'({trigger, 1'b0, enable});
            RA_THR_LO: rdata <= thresh[31:0];
            RA_THR_HI: rdata <= 32'(thresh[CNT_W-1:32]);
            RA_INS_LO: begin
               rdata      <= instr_cnt[31:0];
               ins_shadow <= instr_cnt[CNT_W-1:32];
            end
            RA_INS_HI: rdata <= 32'(ins_shadow);
            RA_CYC_LO: begin
               rdata      <= cyc_cnt[31:0];
               cyc_shadow <= cyc_cnt[CNT_W-1:32];
            end
            RA_CYC_HI: rdata <= 32'(cyc_shadow);
            default:   rdata <= '0;
         endcase
      end
   end

   // R7
   trig_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (trigger && !clr) |=> trigger);
endmodule

// File: rtl/ifetch_perf_counter.sv
module ifetch_perf_counter
   import ifpc_pkg::*;
#(
   parameter int          MEM_DEPTH   = 1024,
   parameter int          WAIT_STATES = 1,
   parameter int          CNT_W       = 40,
   parameter logic [31:0] ROM_SEED    = 32'h5A5A0F0F,
   localparam int         AW          = $clog2(MEM_DEPTH)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              fetch_req,
   input  logic [AW-1:0]     fetch_addr,
   output logic              fetch_wait,
   output logic [31:0]       fetch_rdata,
   output logic              fetch_rvalid,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              count_trigger
);
   if (CNT_W <= 32 || CNT_W > 63) begin : g_bad_cnt
      $error("CNT_W must lie in 33..63");
   end
   if (MEM_DEPTH < 2 || (1 << AW) != MEM_DEPTH) begin : g_bad_depth
      $error("MEM_DEPTH must be a power of two, at least 2");
   end

   logic             accept;
   logic             enable;
   logic             ctrl_clr;
   logic [1:0]       cnt_inc;
   logic [CNT_W-1:0] cnt_q [2];
   logic [CNT_W-1:0] instr_cnt;
   logic [CNT_W-1:0] cyc_cnt;

   ifpc_fetch_port #(
      .AW(AW), .WAIT_STATES(WAIT_STATES), .ROM_SEED(ROM_SEED)
   ) u_fetch (
      .clk(clk), .rst(rst), .req(fetch_req), .addr(fetch_addr),
      .wait_o(fetch_wait), .rdata(fetch_rdata), .rvalid(fetch_rvalid),
      .accept(accept)
   );

   assign cnt_inc[0] = accept && enable;
   assign cnt_inc[1] = enable;

   for (genvar gi = 0; gi < 2; gi++) begin : g_cnt
      ifpc_counter #(.W(CNT_W)) u_cnt (
         .clk(clk), .rst(rst), .clr(ctrl_clr), .inc(cnt_inc[gi]),
         .count(cnt_q[gi])
      );
   end

   assign instr_cnt = cnt_q[0];
   assign cyc_cnt   = cnt_q[1];

   ifpc_regs #(.CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata), .instr_cnt(instr_cnt),
      .cyc_cnt(cyc_cnt), .enable(enable), .clr(ctrl_clr),
      .trigger(count_trigger)
   );

   // R2
   held_fetch_once_chk: assert property (@(posedge clk) disable iff (rst)
      (fetch_req && fetch_wait && !ctrl_clr) |=> (instr_cnt == $past(instr_cnt)));

   // R4
   instr_le_cycles_chk: assert property (@(posedge clk) disable iff (rst)
      instr_cnt <= cyc_cnt);

   // R8
   clear_zeroes_chk: assert property (@(posedge clk) disable iff (rst)
      ctrl_clr |=> (instr_cnt == '0 && cyc_cnt == '0 && !count_trigger));
endmodule

// File: tb/ifetch_perf_counter_tb_top.sv
module ifetch_perf_counter_tb_top;
   localparam int          DEPTH = 1024;
   localparam int          AW    = $clog2(DEPTH);
   localparam int          WS    = 1;
   localparam logic [31:0] SEED  = 32'h5A5A0F0F;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          fetch_req = 1'b0;
   logic [AW-1:0] fetch_addr = '0;
   logic          fetch_wait;
   logic [31:0]   fetch_rdata;
   logic          fetch_rvalid;
   logic          reg_wr = 1'b0;
   logic          reg_rd = 1'b0;
   logic [2:0]    reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic          count_trigger;

   int tests = 0;
   int fails = 0;
   int edge_n = 0;
   bit done = 0;
   logic [31:0] exp_q [$];

   ifetch_perf_counter #(.MEM_DEPTH(DEPTH), .WAIT_STATES(WS), .ROM_SEED(SEED)) dut_i (
      .clk(clk), .rst(rst), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
      .fetch_wait(fetch_wait), .fetch_rdata(fetch_rdata), .fetch_rvalid(fetch_rvalid),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .count_trigger(count_trigger)
   );

   always #5 clk = ~clk;
   always @(posedge clk) edge_n <= edge_n + 1;

   function automatic logic [31:0] model_word(input logic [AW-1:0] a);
      return (32'(a) * 32'h9E3779B1) ^ SEED;
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // monitor: pops expected fetch words as the design returns them (R1)
   always @(negedge clk) begin
      if (!rst && fetch_rvalid) begin
         if (exp_q.size() == 0) check("R1 unexpected rvalid", 64'd1, 64'd0);
         else check("R1 fetch data", 64'(fetch_rdata), 64'(exp_q.pop_front()));
      end
   end

   task automatic fetch(input logic [AW-1:0] a);
      fetch_req  = 1'b1;
      fetch_addr = a;
      #1;
      check("R2 wait on new request", 64'(fetch_wait), 64'(WS > 0));
      while (fetch_wait) @(negedge clk);
      #1;
      while (fetch_wait) @(negedge clk);
      exp_q.push_back(model_word(a));
      @(negedge clk);
      fetch_req = 1'b0;
   endtask

   task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
      reg_rd = 1'b1; reg_addr = a;
      @(negedge clk);
      reg_rd = 1'b0;
      d = reg_rdata;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         fails++; tests++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      int e0, e1, k;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);

      // R9 reset state
      check("R9 trigger after reset", 64'(count_trigger), 64'd0);
      reg_read(3'd0, d); check("R9 ctrl after reset", 64'(d), 64'd0);
      reg_read(3'd1, d); check("R9 threshold after reset", 64'(d), 64'd0);
      reg_read(3'd3, d); check("R9 instr count after reset", 64'(d), 64'd0);
      reg_read(3'd5, d); check("R9 cycle count after reset", 64'(d), 64'd0);

      // R3 fetches while disabled return data but do not count
      fetch(10'd0); fetch(10'd1023); fetch(10'd77);
      @(negedge clk);
      reg_read(3'd3, d); check("R3 no count while disabled", 64'(d), 64'd0);

      // R3 R4 counted window
      reg_write(3'd0, 32'd1);
      e0 = edge_n;
      k = 0;
      for (int i = 0; i < 6; i++) begin
         fetch(AW'(i * 171 + 3)); k++;
      end
      reg_write(3'd0, 32'd0);
      e1 = edge_n;
      reg_read(3'd3, d); check("R3 instr count", 64'(d), 64'(k));
      reg_read(3'd4, d); check("R6 instr high word", 64'(d), 64'd0);
      reg_read(3'd5, d); check("R4 cycle count", 64'(d), 64'(e1 - e0));
      reg_read(3'd6, d); check("R6 cycle high word", 64'(d), 64'd0);
      reg_read(3'd0, d); check("R5 ctrl readback", 64'(d), 64'd0);

      // R8 clear
      reg_write(3'd0, 32'd2);
      reg_read(3'd3, d); check("R8 instr cleared", 64'(d), 64'd0);
      reg_read(3'd5, d); check("R8 cycles cleared", 64'(d), 64'd0);

      // R7 threshold trigger
      reg_write(3'd1, 32'd5);
      reg_read(3'd1, d); check("R5 threshold readback", 64'(d), 64'd5);
      reg_write(3'd0, 32'd1);
      for (int i = 0; i < 4; i++) fetch(AW'(500 + i));
      repeat (2) @(negedge clk);
      check("R7 no trigger below threshold", 64'(count_trigger), 64'd0);
      fetch(10'd600);
      repeat (2) @(negedge clk);
      check("R7 trigger at threshold", 64'(count_trigger), 64'd1);
      fetch(10'd601); fetch(10'd602);
      repeat (2) @(negedge clk);
      check("R7 trigger sticky", 64'(count_trigger), 64'd1);
      reg_read(3'd0, d); check("R7 status bit", 64'(d), 64'd5);
      reg_write(3'd0, 32'd3);
      @(negedge clk);
      check("R8 trigger cleared", 64'(count_trigger), 64'd0);
      reg_read(3'd0, d); check("R8 enable kept by clear write", 64'(d), 64'd1);

      // R7 upper threshold bits take part
      reg_write(3'd2, 32'd1);
      reg_write(3'd1, 32'd2);
      reg_write(3'd0, 32'd3);
      for (int i = 0; i < 3; i++) fetch(AW'(900 + i));
      repeat (2) @(negedge clk);
      check("R7 high threshold not reached", 64'(count_trigger), 64'd0);
      reg_read(3'd2, d); check("R5 threshold high readback", 64'(d), 64'd1);

      // R9 reset mid-run
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      reg_read(3'd2, d); check("R9 threshold high cleared", 64'(d), 64'd0);
      reg_read(3'd0, d); check("R9 ctrl cleared", 64'(d), 64'd0);
      reg_read(3'd3, d); check("R9 instr cleared", 64'(d), 64'd0);

      check("R1 all fetches returned", 64'(exp_q.size()), 64'd0);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule